// File: doc/BRIEF.md
# Static Memory Area Cycle Controller

This block runs external bus cycles for one chip-select window that holds ordinary SRAM or ROM. An internal requester presents an address, a direction and write data, and holds its request until a one-cycle acknowledge returns. If the address falls in this block's window, the controller drives the chip select and then the output-enable strobe or the byte-lane write strobes. It places programmable setup and hold times around the strobe in half-cycle steps. It inserts a programmed number of wait cycles and stretches the strobe while the external wait input is active.

Timing fields come from configuration inputs and are captured when a request is accepted. A burst option turns a read into a fixed run of beats under one chip select. The address advances by the access size on each beat, and the beat pitch follows the wait setting. Strobes change on the falling clock edge and chip select changes on the rising edge, so the setup and hold intervals both end on a half cycle.

Top module: `smc_area`

## Requirements
- R1: A request is accepted only when address bits 28:26 equal the area code (3'b110 by default). Bits 31:29 are ignored, so all eight values alias. A non-matching request produces no chip select and no acknowledge.
- R2: The 3-bit wait code selects 0, 1, 2, 3, 4, 6, 8 or 10 wait cycles for codes 0 to 7. A single access holds its strobe low for waits+1 clock cycles.
- R3: For setup code k (0..7), the strobe goes low k+0.5 cycles after chip select goes low. Chip select goes low at the first rising edge after the request is presented.
- R4: For hold code h (0..7), chip select returns high h+0.5 cycles after the strobe returns high.
- R5: A read drives chip select and `oe_n` low and keeps `wr_n` at 4'hF. It returns the bus data sampled at the last strobe edge on `rdata`, with `rvalid`. It raises `ack` exactly once, for one cycle, in the cycle after that edge.
- R6: A write keeps `oe_n` high and drives the bus data with `bus_doe` high. The `wr_n` bits low select the lanes: size 0 (byte) gives lane addr[1:0]; size 1 (word) gives lanes 3:2 if addr[1] is set, else lanes 1:0; size 2 or 3 (long) gives all four lanes.
- R7: `wait_n` passes through a two-flop synchronizer. It is examined only at the last programmed strobe cycle, and while it reads low the strobe is extended one cycle at a time with no limit. An early wait pulse that ends before then has no effect.
- R8: With `cfg_burst` set, a read runs 4 beats under one chip select, each lasting max(2, waits+1) cycles. Each beat's data comes out with `rvalid`, the bus address advances by 1, 2 or 4 bytes per beat according to the size, and `ack` follows the last beat. Writes ignore `cfg_burst`.
- R9: Configuration inputs are captured when a request is accepted. Changing them during an access does not alter its timing.
- R10: During reset chip select and all strobes are high and `ack` and `rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Lane-aligned write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data from the bus |
| rvalid | output | 1 | rdata valid (once per read beat) |
| cfg_wait | input | 3 | Wait code |
| cfg_setup | input | 3 | Setup code, k+0.5 cycles |
| cfg_hold | input | 3 | Hold code, h+0.5 cycles |
| cfg_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| cfg_burst | input | 1 | Burst read enable |
| wait_n | input | 1 | Asynchronous external wait, active low |
| cs_n | output | 1 | Area chip select |
| oe_n | output | 1 | Read strobe / output enable |
| wr_n | output | 4 | Per-lane write strobes |
| bus_addr | output | 26 | Address within the area |
| bus_dout | output | 32 | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 32 | Read data from the bus |

## Verification
The assertions assume that the requester keeps `req` and its address stable until `ack`. They also assume that `bus_din` is a function of `bus_addr` alone, so captured data depends only on which beat was sampled. The bench drops `req` right after it sees `ack`, so no second access starts by accident. It changes `wait_n` and the configuration only half a cycle away from a rising edge and never during reset. The external wait is the only asynchronous input. The bench moves it at chosen cycle offsets so that the synchronizer delay can be counted exactly.

// File: rtl/smc_area.sv
module smc_area #(
  parameter logic [2:0] AREA_CODE   = 3'b110,
  parameter int         BURST_BEATS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_we,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        ack,
  output logic [31:0] rdata,
  output logic        rvalid,
  input  logic [2:0]  cfg_wait,
  input  logic [2:0]  cfg_setup,
  input  logic [2:0]  cfg_hold,
  input  logic [1:0]  cfg_size,
  input  logic        cfg_burst,
  input  logic        wait_n,
  output logic        cs_n,
  output logic        oe_n,
  output logic [3:0]  wr_n,
  output logic [25:0] bus_addr,
  output logic [31:0] bus_dout,
  output logic        bus_doe,
  input  logic [31:0] bus_din
);
  localparam int BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t         st;
  logic [3:0]  cnt, wq;
  logic [2:0]  hold_q;
  logic [1:0]  size_q, wsync;
  logic        we_q, burst_q;
  logic [BW-1:0] beat;

  function automatic logic [3:0] wmap(input logic [2:0] c);
    case (c)
      3'd5:    return 4'd6;
      3'd6:    return 4'd8;
      3'd7:    return 4'd10;
      default: return {1'b0, c};
    endcase
  endfunction

  function automatic logic [3:0] strobe_ld(input logic [3:0] w, input logic b);
    return (b && w == 4'd0) ? 4'd1 : w;
  endfunction

  wire hit       = req_addr[28:26] == AREA_CODE;
  wire strobe_on = st == S_STROBE;
  wire last_cyc  = strobe_on && cnt == 4'd0;
  wire waiting   = wsync[1];
  wire last_beat = !burst_q || beat == BW'(BURST_BEATS - 1);
  wire burst_new = cfg_burst & ~req_we;

  logic [3:0]  lanes;
  logic [25:0] step;
  always_comb begin
    case (size_q)
      2'd0:    begin lanes = 4'b0001 << bus_addr[1:0]; step = 26'd1; end
      2'd1:    begin lanes = bus_addr[1] ? 4'b1100 : 4'b0011; step = 26'd2; end
      default: begin lanes = 4'b1111; step = 26'd4; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wsync <= 2'b00;
    else        wsync <= {wsync[0], ~wait_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wq <= '0; hold_q <= '0; size_q <= '0;
      we_q <= 1'b0; burst_q <= 1'b0; beat <= '0;
      cs_n <= 1'b1; ack <= 1'b0; rvalid <= 1'b0; rdata <= '0;
      bus_addr <= '0; bus_dout <= '0; bus_doe <= 1'b0;
    end else begin
      ack    <= 1'b0;
      rvalid <= 1'b0;
      case (st)
        S_IDLE: if (req && hit) begin
          cs_n     <= 1'b0;
          we_q     <= req_we;
          size_q   <= cfg_size;
          burst_q  <= burst_new;
          wq       <= wmap(cfg_wait);
          hold_q   <= cfg_hold;
          bus_addr <= req_addr[25:0];
          bus_dout <= req_wdata;
          bus_doe  <= req_we;
          beat     <= '0;
          if (cfg_setup == 3'd0) begin
            st  <= S_STROBE;
            cnt <= strobe_ld(wmap(cfg_wait), burst_new);
          end else begin
            st  <= S_SETUP;
            cnt <= {1'b0, cfg_setup};
          end
        end
        S_SETUP:
          if (cnt <= 4'd1) begin
            st  <= S_STROBE;
            cnt <= strobe_ld(wq, burst_q);
          end else cnt <= cnt - 4'd1;
        S_STROBE:
          if (cnt != 4'd0) cnt <= cnt - 4'd1;
          else if (!waiting) begin
            if (!we_q) begin
              rdata  <= bus_din;
              rvalid <= 1'b1;
            end
            if (last_beat) begin
              st  <= S_HOLD;
              cnt <= {1'b0, hold_q};
              ack <= 1'b1;
            end else begin
              beat     <= beat + BW'(1);
              bus_addr <= bus_addr + step;
              cnt      <= strobe_ld(wq, 1'b1);
            end
          end
        default:
          if (cnt == 4'd0) begin
            st      <= S_IDLE;
            cs_n    <= 1'b1;
            bus_doe <= 1'b0;
          end else cnt <= cnt - 4'd1;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      oe_n <= 1'b1;
      wr_n <= 4'hF;
    end else begin
      oe_n <= ~(strobe_on & ~we_q);
      wr_n <= ~(lanes & {4{strobe_on & we_q}});
    end

  p_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req && !hit) |=> cs_n);
  p_alias_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req && hit && req_addr[31:29] != 3'd0) |=> !cs_n);
  p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || wr_n != 4'hF) |-> !cs_n);
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && wr_n != 4'hF));
  p_lane_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n != 4'hF) |-> ($countones(~wr_n) == 1 || $countones(~wr_n) == 2 || $countones(~wr_n) == 4));
  p_wait_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && waiting) |=> (st == S_STROBE && !ack));
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !burst_q && st != S_HOLD) |=> $stable(bus_addr));
endmodule

// File: tb/test_smc_area.sv
`timescale 1ns/1ps
module test_smc_area;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic ack, rvalid, cs_n, oe_n, bus_doe;
  logic [31:0] rdata, bus_dout, bus_din;
  logic [3:0] wr_n;
  logic [25:0] bus_addr;
  logic [2:0] cfg_wait = '0, cfg_setup = '0, cfg_hold = '0;
  logic [1:0] cfg_size = 2'd2;
  logic cfg_burst = 1'b0, wait_n = 1'b1;

  int n_tests = 0, n_fail = 0;
  int cs_first, cs_last, st_first, st_last, ack_idx, ack_cnt, rv_cnt;
  logic [3:0] we_seen;
  logic rd_seen, doe_bad;
  logic [31:0] dout_seen;
  logic [31:0] rv_data [8];

  always #2 clk = ~clk;

  function automatic logic [31:0] mdat(input logic [25:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8], ~a[7:0], a[23:16] ^ {6'd0, a[25:24]}};
  endfunction

  assign bus_din = mdat(bus_addr);

  smc_area i_smc_area (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .rvalid(rvalid),
    .cfg_wait(cfg_wait), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_size(cfg_size), .cfg_burst(cfg_burst), .wait_n(wait_n),
    .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din));

  function automatic int wmap(input int c);
    return (c <= 4) ? c : 2 * c - 4;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run(input logic we, input logic [31:0] a, input logic [31:0] wd,
                     input int rel, input bit poke);
    logic [2:0] sw, ss, sh;
    bit done;
    cs_first = -1; cs_last = -1; st_first = -1; st_last = -1;
    ack_idx = -1; ack_cnt = 0; rv_cnt = 0; we_seen = 4'h0; rd_seen = 1'b0;
    doe_bad = 1'b0; dout_seen = '0; done = 1'b0;
    sw = cfg_wait; ss = cfg_setup; sh = cfg_hold;
    @(negedge clk); #1;
    if (rel >= 0) wait_n = 1'b0;
    req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    for (int i = 0; i < 600 && !done; i++) begin
      if (i % 2 == 0) @(posedge clk); else @(negedge clk);
      #1;
      if (!cs_n) begin
        if (cs_first < 0) cs_first = i;
        cs_last = i;
      end
      if (!oe_n || wr_n != 4'hF) begin
        if (st_first < 0) st_first = i;
        st_last = i;
        we_seen = we_seen | ~wr_n;
        if (!oe_n) rd_seen = 1'b1;
        if (wr_n != 4'hF) begin
          dout_seen = bus_dout;
          if (!bus_doe) doe_bad = 1'b1;
        end
      end
      if (i % 2 == 0 && ack) begin
        ack_cnt++; ack_idx = i; req = 1'b0;
      end
      if (i % 2 == 0 && rvalid && rv_cnt < 8) begin
        rv_data[rv_cnt] = rdata; rv_cnt++;
      end
      if (rel >= 0 && i == 2 * rel) wait_n = 1'b1;
      if (poke && i == 2) begin
        cfg_wait = ~sw; cfg_setup = ~ss; cfg_hold = ~sh;
      end
      if (cs_first >= 0 && cs_n) done = 1'b1;
      if (cs_first < 0 && i >= 60) done = 1'b1;
    end
    req = 1'b0; wait_n = 1'b1;
    cfg_wait = sw; cfg_setup = ss; cfg_hold = sh;
    @(negedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cs_n == 1'b1 && oe_n == 1'b1 && wr_n == 4'hF, "R10", {cs_n, oe_n, wr_n}, 6'h3F);
    chk(ack == 1'b0 && rvalid == 1'b0, "R10", {ack, rvalid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 sweep; upper bits 31:29 take all values (R1 aliasing)
    for (int w = 0; w < 8; w++)
      for (int s = 0; s < 8; s++) begin
        logic [31:0] a;
        int h;
        h = (w + s) % 8;
        cfg_wait = 3'(w); cfg_setup = 3'(s); cfg_hold = 3'(h);
        cfg_size = 2'd2; cfg_burst = 1'b0;
        a = {3'(w), 3'b110, 26'(s * 1024 + w * 4 + 3)};
        run(1'b0, a, 32'd0, -1, 1'b0);
        chk(cs_first == 0, "R1 hit", cs_first, 0);
        chk(st_first - cs_first == 2 * s + 1, "R3 setup", st_first - cs_first, 2 * s + 1);
        chk(st_last - st_first + 1 == 2 * (wmap(w) + 1), "R2 width",
            st_last - st_first + 1, 2 * (wmap(w) + 1));
        chk(cs_last - st_last == 2 * h + 1, "R4 hold", cs_last - st_last, 2 * h + 1);
        chk(ack_cnt == 1 && ack_idx == 2 * (s + wmap(w) + 1), "R5 ack", ack_idx, 2 * (s + wmap(w) + 1));
        chk(rv_cnt == 1 && rv_data[0] == mdat(a[25:0]), "R5 data", rv_data[0], mdat(a[25:0]));
        chk(we_seen == 4'h0 && rd_seen, "R5 strobes", we_seen, 0);
      end

    // R1 misses
    cfg_wait = 3'd1; cfg_setup = 3'd1; cfg_hold = 3'd1;
    for (int c = 0; c < 8; c++) if (c != 6) begin
      run(1'b0, {3'(7 - c), 3'(c), 26'h40}, 32'd0, -1, 1'b0);
      chk(cs_first < 0 && ack_cnt == 0, "R1 miss", ack_cnt, 0);
    end

    // R6 write lanes
    cfg_wait = 3'd1; cfg_setup = 3'd1; cfg_hold = 3'd0; cfg_burst = 1'b0;
    for (int sz = 0; sz < 4; sz++)
      for (int lo = 0; lo < 4; lo++) begin
        logic [3:0] el;
        logic [31:0] wd;
        el = (sz == 0) ? (4'b0001 << lo) : (sz == 1) ? ((lo >= 2) ? 4'b1100 : 4'b0011) : 4'b1111;
        wd = 32'hC0DE0000 | 32'(sz * 16 + lo);
        cfg_size = 2'(sz);
        run(1'b1, {6'b000110, 24'h1234A, 2'(lo)}, wd, -1, 1'b0);
        chk(we_seen == el, "R6 lanes", we_seen, el);
        chk(!rd_seen && !doe_bad && dout_seen == wd, "R6 data", dout_seen, wd);
        chk(ack_cnt == 1 && st_last - st_first + 1 == 4, "R6 width", st_last - st_first + 1, 4);
      end

    // R7 external wait
    cfg_wait = 3'd2; cfg_setup = 3'd1; cfg_hold = 3'd1; cfg_size = 2'd2;
    for (int m = 0; m < 7; m++) begin
      int x;
      x = (m + 3 > 4) ? m + 3 : 4;
      run(1'b0, 32'h18000100, 32'd0, m, 1'b0);
      chk(ack_cnt == 1 && ack_idx == 2 * x, "R7 stretch", ack_idx, 2 * x);
      chk(st_last - st_first + 1 == 2 * (x - 1), "R7 width", st_last - st_first + 1, 2 * (x - 1));
    end

    // R8 burst reads
    cfg_setup = 3'd0; cfg_hold = 3'd0; cfg_burst = 1'b1;
    for (int sz = 1; sz < 3; sz++)
      for (int w = 0; w < 4; w++) begin
        int p, stp;
        logic [31:0] a;
        p = (wmap(w) + 1 < 2) ? 2 : wmap(w) + 1;
        stp = (sz == 1) ? 2 : 4;
        cfg_size = 2'(sz); cfg_wait = 3'(w);
        a = 32'h18002000 + 32'(w * 64);
        run(1'b0, a, 32'd0, -1, 1'b0);
        chk(rv_cnt == 4 && ack_cnt == 1, "R8 beats", rv_cnt, 4);
        chk(ack_idx == 8 * p, "R8 pitch", ack_idx, 8 * p);
        chk(st_last - st_first + 1 == 8 * p, "R8 width", st_last - st_first + 1, 8 * p);
        for (int b = 0; b < 4; b++) begin
          logic [25:0] ea;
          ea = a[25:0] + 26'(b * stp);
          chk(rv_data[b] == mdat(ea), "R8 data", rv_data[b], mdat(ea));
        end
      end
    cfg_wait = 3'd1; cfg_size = 2'd2;
    run(1'b1, 32'h18000400, 32'h55AA55AA, -1, 1'b0);
    chk(ack_cnt == 1 && ack_idx == 4 && we_seen == 4'hF, "R8 write single", ack_idx, 4);

    // R9 configuration captured at acceptance
    cfg_burst = 1'b0; cfg_wait = 3'd3; cfg_setup = 3'd2; cfg_hold = 3'd2;
    run(1'b0, 32'h18000800, 32'd0, -1, 1'b1);
    chk(ack_idx == 2 * (2 + 3 + 1), "R9 timing", ack_idx, 12);
    chk(cs_last - st_last == 5, "R9 hold", cs_last - st_last, 5);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule